// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital controller that sits in front of a 10-bit successive-approximation converter core. It decides which analog channel is converted next and starts each conversion over a start/done handshake with the core. It stores each returned code in a result register owned by that channel. When a sequence is complete it raises a completion flag, and it raises an interrupt request when that is enabled.

Software drives the block through a small register bus. A control word at address 0 holds several fields: a run bit, which also reads as busy; an interrupt enable; the completion flag; a mode field; and a channel field. The result registers follow at addresses 1 to NUM_CH. A timer trigger pulse or an external trigger pulse can also set the run bit while the block is idle.

There are three modes:

- **Single:** converts the chosen channel once.
- **One-pass scan:** converts channels 0 up to the chosen channel once, in ascending order.
- **Looping scan:** repeats that pass for as long as the run bit stays 1.

Clearing the run bit aborts the sequence at once.

The state machine has three states: IDLE, LAUNCH and WAIT.

| Transition | Condition | Action |
|---|---|---|
| IDLE to LAUNCH | run bit is 1 | Loads the first channel of the sequence |
| LAUNCH to WAIT | run bit still 1 | Issues the one-cycle start pulse |
| LAUNCH to IDLE | run bit has been cleared | None |
| WAIT to LAUNCH (step) | done arrives and the channel is not the last | Stores the code and advances to the next channel |
| WAIT to LAUNCH (wrap) | done arrives on the last channel in looping scan | Stores the code, sets the flag and returns to channel 0 |
| WAIT to IDLE (finish) | done arrives on the last channel in single or one-pass mode | Stores the code, sets the flag and self-clears the run bit |
| WAIT to IDLE (abort) | run bit cleared | Pulses the abort output to the core and stores nothing |

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control word at address 0 reads 0, every result register reads 0, and irq and conv_start are 0.
- R2: In single mode (mode field bits [4:3] = 00), setting the run bit (control bit 0) converts exactly the channel in the channel field (bits [7:5]) once. The run bit reads 1 while the conversion is pending, then clears itself, and the block returns to IDLE.
- R3: In one-pass scan (mode = 10, and also 11), channels 0 up to the channel field are converted once each in ascending order. The completion flag is then set and the run bit clears itself.
- R4: In looping scan (mode = 01), passes over channels 0 up to the channel field repeat while the run bit is 1. The completion flag is set only when the last channel of a pass completes. The run bit stays 1.
- R5: Each completed conversion writes the 10-bit code into the result register of its channel, at bus address 1 + channel.
- R6: Writing 0 to the run bit while a conversion is outstanding pulses conv_abort and returns the block to IDLE. That conversion writes no result register and does not set the flag.
- R7: A one-cycle pulse on trig_timer or trig_ext while the run bit is 0 sets the run bit and starts the configured sequence.
- R8: A trigger pulse that arrives while the run bit is 1 has no effect: the number and order of conversions are unchanged.
- R9: The completion flag (control bit 2) is cleared by a control write with bit 2 = 0. A write with bit 2 = 1 leaves it unchanged.
- R10: irq is 1 exactly when both the completion flag and the interrupt enable (control bit 1) are 1.
- R11: conv_start is a one-cycle pulse, and no new start is issued while a conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address (0 = control, 1..8 = results) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| trig_timer | input | 1 | Timer trigger pulse |
| trig_ext | input | 1 | External trigger pulse |
| conv_start | output | 1 | Start pulse to the converter core |
| conv_abort | output | 1 | Abort pulse to the converter core |
| conv_ch | output | 3 | Channel for the current conversion |
| conv_done | input | 1 | Core reports a finished conversion |
| conv_code | input | 10 | Code returned by the core |
| irq | output | 1 | Interrupt request |

## Verification
A wrong channel counter shows up in two ways. The core model records the channel order, which differs from the expected ascending sequence on the very next conversion. The result register addressed by a misrouted write also holds a wrong code. A state machine that misses the last channel shows up quickly. Either the flag never rises, which the bench's timeout catches, or the run bit stays 1 in single and one-pass modes when it is read back within a few cycles of completion. A missing abort becomes visible within one conversion latency: the late code lands in a result register that should have kept its old value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_LOOP   = 2'b01,
        MODE_ONCE   = 2'b10,
        MODE_ONCE_B = 2'b11
    } seq_mode_e;

    localparam int CTL_RUN      = 0;
    localparam int CTL_IE       = 1;
    localparam int CTL_FLAG     = 2;
    localparam int CTL_MODE_LSB = 3;
    localparam int CTL_SEL_LSB  = 5;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic             trig_req,
    input  logic             seq_end,
    input  logic             self_clear,
    output logic             run,
    output logic             ie,
    output logic             flag,
    output seq_mode_e        mode,
    output logic [CH_W-1:0]  sel
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            ie   <= 1'b0;
            flag <= 1'b0;
            mode <= MODE_SINGLE;
            sel  <= '0;
        end else begin
            if (self_clear) begin
                run <= 1'b0;
            end
            if (ctl_we) begin
                run  <= wdata[CTL_RUN];
                ie   <= wdata[CTL_IE];
                flag <= flag & wdata[CTL_FLAG];
                mode <= seq_mode_e'(wdata[CTL_MODE_LSB +: 2]);
                sel  <= wdata[CTL_SEL_LSB +: CH_W];
            end else if (trig_req && !run) begin
                run <= 1'b1;
            end
            if (seq_end) begin
                flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  seq_mode_e       mode,
    input  logic [CH_W-1:0] sel,
    input  logic            conv_done,
    output logic            conv_start,
    output logic            conv_abort,
    output logic [CH_W-1:0] conv_ch,
    output logic            res_we,
    output logic            seq_end,
    output logic            self_clear,
    output logic            busy
);

    seq_state_e      state_q, state_d;
    logic [CH_W-1:0] ch_q, ch_d;
    logic [CH_W-1:0] first_ch;
    logic            last_hit;

    assign first_ch = (mode == MODE_SINGLE) ? sel : '0;
    assign last_hit = (ch_q == sel);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin
                    state_d = ST_LAUNCH;
                    ch_d    = first_ch;
                end
            end
            ST_LAUNCH: begin
                state_d = run ? ST_WAIT : ST_IDLE;
            end
            ST_WAIT: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (conv_done) begin
                    if (!last_hit) begin
                        state_d = ST_LAUNCH;
                        ch_d    = ch_q + 1'b1;
                    end else if (mode == MODE_LOOP) begin
                        state_d = ST_LAUNCH;
                        ch_d    = '0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        conv_start = 1'b0;
        conv_abort = 1'b0;
        res_we     = 1'b0;
        seq_end    = 1'b0;
        self_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LAUNCH: conv_start = run;
            ST_WAIT: begin
                if (!run) begin
                    conv_abort = 1'b1;
                end else if (conv_done) begin
                    res_we     = 1'b1;
                    seq_end    = last_hit;
                    self_clear = last_hit && (mode != MODE_LOOP);
                end
            end
            default: ;
        endcase
    end

    assign conv_ch = ch_q;
    assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [RES_W-1:0] wr_code,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_code
);

    logic [RES_W-1:0] bank [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (we && (wr_ch == CH_W'(g))) begin
                bank[g] <= wr_code;
            end
        end
    end

    assign rd_code = bank[rd_ch];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int RES_W   = 10,
    parameter int BUS_W   = 16,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              trig_timer,
    input  logic              trig_ext,
    output logic              conv_start,
    output logic              conv_abort,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_code,
    output logic              irq
);

    logic            ctl_we;
    logic            run_q, ie_q, flag_q;
    seq_mode_e       mode_q;
    logic [CH_W-1:0] sel_q;
    logic            res_we, seq_end, self_clear, busy;
    logic [ADDR_W-1:0] addr_m1;
    logic [CH_W-1:0]   rd_idx;
    logic [RES_W-1:0]  rd_code;
    logic              rd_is_res;
    logic [BUS_W-1:0]  ctl_word;

    assign ctl_we = bus_we && (bus_addr == '0);

    adc_seq_regs #(.CH_W(CH_W), .BUS_W(BUS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .wdata      (bus_wdata),
        .trig_req   (trig_timer | trig_ext),
        .seq_end    (seq_end),
        .self_clear (self_clear),
        .run        (run_q),
        .ie         (ie_q),
        .flag       (flag_q),
        .mode       (mode_q),
        .sel        (sel_q)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .mode       (mode_q),
        .sel        (sel_q),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_abort (conv_abort),
        .conv_ch    (conv_ch),
        .res_we     (res_we),
        .seq_end    (seq_end),
        .self_clear (self_clear),
        .busy       (busy)
    );

    assign addr_m1   = bus_addr - ADDR_W'(1);
    assign rd_idx    = addr_m1[CH_W-1:0];
    assign rd_is_res = (bus_addr != '0) && (bus_addr <= ADDR_W'(NUM_CH));

    adc_seq_results #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (res_we),
        .wr_ch   (conv_ch),
        .wr_code (conv_code),
        .rd_ch   (rd_idx),
        .rd_code (rd_code)
    );

    always_comb begin
        ctl_word                           = '0;
        ctl_word[CTL_RUN]                  = run_q;
        ctl_word[CTL_IE]                   = ie_q;
        ctl_word[CTL_FLAG]                 = flag_q;
        ctl_word[CTL_MODE_LSB +: 2]        = mode_q;
        ctl_word[CTL_SEL_LSB +: CH_W]      = sel_q;
    end

    always_comb begin
        if (bus_addr == '0) begin
            bus_rdata = ctl_word;
        end else if (rd_is_res) begin
            bus_rdata = BUS_W'(rd_code);
        end else begin
            bus_rdata = '0;
        end
    end

    assign irq = flag_q & ie_q;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_start,
    input logic conv_done,
    input logic res_we,
    input logic flag,
    input logic seq_end,
    input logic busy,
    input logic run,
    input logic ctl_we
);

    a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r5_store_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> conv_done);

    a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(seq_end));

    a_r6_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !run) |=> !busy);

    a_r2_self_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run) && !$past(ctl_we)) |-> $past(seq_end));

    a_r8_run_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctl_we && !seq_end) |=> run);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .res_we     (res_we),
    .flag       (flag_q),
    .seq_end    (seq_end),
    .busy       (busy),
    .run        (run_q),
    .ctl_we     (ctl_we)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    localparam int NUM_CH = 8;
    localparam int RES_W  = 10;
    localparam int BUS_W  = 16;
    localparam int CH_W   = 3;
    localparam int ADDR_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic trig_timer = 1'b0, trig_ext = 1'b0;
    logic conv_start, conv_abort, irq;
    logic [CH_W-1:0] conv_ch;
    logic conv_done;
    logic [RES_W-1:0] conv_code;

    always #2 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_timer(trig_timer),
        .trig_ext(trig_ext), .conv_start(conv_start), .conv_abort(conv_abort),
        .conv_ch(conv_ch), .conv_done(conv_done), .conv_code(conv_code), .irq(irq)
    );

    // converter core model
    int lat = 3;
    bit honor_abort = 1'b1;
    int seq_ch [256];
    int seq_n = 0;
    int abort_seen = 0;
    logic [RES_W-1:0] last_code [NUM_CH];
    bit m_busy = 1'b0;
    int m_cnt = 0;
    int m_ch = 0;

    function automatic logic [RES_W-1:0] code_of(int n, int ch);
        return RES_W'((n * 37 + ch * 101 + 3) % 1024);
    endfunction

    initial begin
        for (int i = 0; i < NUM_CH; i++) last_code[i] = '0;
        conv_done = 1'b0;
        conv_code = '0;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            conv_done <= 1'b0;
            if (conv_abort) abort_seen <= abort_seen + 1;
            if (conv_abort && honor_abort) begin
                m_busy <= 1'b0;
            end else if (conv_start) begin
                m_busy <= 1'b1;
                m_cnt  <= lat;
                m_ch   <= int'(conv_ch);
            end else if (m_busy) begin
                if (m_cnt <= 1) begin
                    conv_done <= 1'b1;
                    conv_code <= code_of(seq_n, m_ch);
                    last_code[m_ch] <= code_of(seq_n, m_ch);
                    seq_ch[seq_n % 256] <= m_ch;
                    seq_n <= seq_n + 1;
                    m_busy <= 1'b0;
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] ctl(bit run, bit ie, bit keep, int mode, int sel);
        return BUS_W'(int'(run) | (int'(ie) << 1) | (int'(keep) << 2) | (mode << 3) | (sel << 5));
    endfunction

    task automatic wr(input int a, input logic [BUS_W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = ADDR_W'(a);
        #0.5;
        v = int'(bus_rdata);
        bus_addr = '0;
    endtask

    task automatic wait_flag(input string tag);
        int v;
        for (int i = 0; i < 3000; i++) begin
            rd(0, v);
            if (v[2]) return;
            @(negedge clk);
        end
        chk({tag, " flag timeout"}, 0, 1);
    endtask

    task automatic cmp_results(input string tag);
        int v;
        for (int c = 0; c < NUM_CH; c++) begin
            rd(c + 1, v);
            chk(tag, v, int'(last_code[c]));
        end
    endtask

    task automatic pulse(input bit ext);
        @(negedge clk);
        if (ext) trig_ext = 1'b1; else trig_timer = 1'b1;
        @(negedge clk);
        trig_ext = 1'b0; trig_timer = 1'b0;
    endtask

    initial begin
        int v, s0, ab0;
        logic [RES_W-1:0] prior;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 0);
        for (int c = 0; c < NUM_CH; c++) begin
            rd(c + 1, v); chk("R1 result", v, 0);
        end
        chk("R1 irq", int'(irq), 0);
        chk("R1 conv_start", int'(conv_start), 0);

        // R2 single-mode sweep, R5 storage, R10 irq
        for (int c = 0; c < NUM_CH; c++) begin
            s0 = seq_n;
            wr(0, ctl(1, c[0], 0, 0, c));
            rd(0, v); chk("R2 run reads 1", v & 1, 1);
            wait_flag("R2");
            @(negedge clk);
            rd(0, v); chk("R2 run cleared", v & 1, 0);
            chk("R2 one conversion", seq_n - s0, 1);
            chk("R2 channel", seq_ch[s0 % 256], c);
            chk("R10 irq", int'(irq), c % 2);
            cmp_results("R5 result");
            wr(0, ctl(0, 0, 0, 0, c));
            rd(0, v); chk("R9 flag cleared", (v >> 2) & 1, 0);
        end

        // R3 one-pass scan sweep, both encodings
        for (int s = 0; s < NUM_CH; s++) begin
            s0 = seq_n;
            wr(0, ctl(1, 1, 0, (s % 2) ? 3 : 2, s));
            wait_flag("R3");
            @(negedge clk);
            rd(0, v); chk("R3 run cleared", v & 1, 0);
            chk("R3 count", seq_n - s0, s + 1);
            for (int i = 0; i <= s; i++) chk("R3 order", seq_ch[(s0 + i) % 256], i);
            cmp_results("R5 result scan");
            // R9 write with flag bit 1 keeps it, R10 irq follows enable
            wr(0, ctl(0, 0, 1, 2, s));
            rd(0, v); chk("R9 flag kept", (v >> 2) & 1, 1);
            chk("R10 irq masked", int'(irq), 0);
            wr(0, ctl(0, 1, 1, 2, s));
            chk("R10 irq enabled", int'(irq), 1);
            wr(0, ctl(0, 1, 0, 2, s));
            chk("R10 irq after clear", int'(irq), 0);
        end

        // R4 looping scan over channels 0..3
        s0 = seq_n;
        wr(0, ctl(1, 0, 0, 1, 3));
        wait_flag("R4 pass1");
        chk("R4 pass1 count", seq_n - s0, 4);
        rd(0, v); chk("R4 run stays 1", v & 1, 1);
        wr(0, ctl(1, 0, 0, 1, 3));
        for (int i = 0; i < 3000; i++) begin
            rd(0, v);
            if (v[2]) break;
            if (seq_n - s0 < 7) chk("R4 flag early", 0, 0);
            @(negedge clk);
        end
        chk("R4 pass2 count", seq_n - s0, 8);
        for (int i = 0; i < 8; i++) chk("R4 order", seq_ch[(s0 + i) % 256], i % 4);
        wr(0, ctl(0, 0, 0, 1, 3));
        repeat (10) @(negedge clk);
        rd(0, v); chk("R4 stopped", v & 1, 0);
        cmp_results("R5 after loop");

        // R7 trigger start and R8 trigger while busy
        lat = 8;
        s0 = seq_n;
        wr(0, ctl(0, 0, 0, 2, 2));
        pulse(1'b1);
        rd(0, v); chk("R7 ext trigger sets run", v & 1, 1);
        repeat (3) @(negedge clk);
        pulse(1'b0);
        repeat (4) @(negedge clk);
        pulse(1'b1);
        wait_flag("R7");
        @(negedge clk);
        rd(0, v); chk("R8 run cleared", v & 1, 0);
        repeat (30) @(negedge clk);
        chk("R8 no extra conversions", seq_n - s0, 3);
        for (int i = 0; i < 3; i++) chk("R7 order", seq_ch[(s0 + i) % 256], i);
        wr(0, ctl(0, 0, 0, 0, 0));
        s0 = seq_n;
        pulse(1'b0);
        wait_flag("R7 timer");
        chk("R7 timer trigger single", seq_n - s0, 1);
        wr(0, ctl(0, 0, 0, 0, 0));
        cmp_results("R5 after triggers");

        // R6 abort: core completes anyway; result must not be written
        lat = 20;
        honor_abort = 1'b0;
        prior = last_code[5];
        s0 = seq_n;
        ab0 = abort_seen;
        wr(0, ctl(1, 1, 0, 0, 5));
        repeat (5) @(negedge clk);
        rd(0, v); chk("R2 run reads 1 mid", v & 1, 1);
        wr(0, ctl(0, 1, 0, 0, 5));
        repeat (2) @(negedge clk);
        chk("R6 abort pulse", abort_seen - ab0, 1);
        repeat (30) @(negedge clk);
        chk("R6 core finished late", seq_n - s0, 1);
        rd(6, v); chk("R6 result untouched", v, int'(prior));
        rd(0, v); chk("R6 flag not set", (v >> 2) & 1, 0);
        chk("R6 run reads 0", v & 1, 0);
        chk("R6 irq low", int'(irq), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule